// File: doc/BRIEF.md
# Byte-Writable 32-Bit Word Memory

This block is a CPU-facing data memory that stores 32-bit words and accepts byte-granular writes. It is built from two identical 16-bit single-port storage halves that share one word address: the low half holds data bits [15:0] and the high half holds bits [31:16]. Each half supports writes only through a 4-bit nibble mask. The block therefore turns every byte enable into the pair of nibble-mask bits that cover that byte in the correct half.

Each cycle the block takes a word address, write data and a 4-bit byte enable. It returns registered read data on the following cycle. If no byte enable is set, the access is a plain read. In a cycle that both writes and reads, the read returns the contents as they were before the write. The stored contents are undefined after start-up, and the block never clears them. The address width is a parameter. A width of 14 gives the full 16,384-word (64 KiB) memory, and the default is kept smaller for elaboration.

Top module: `byte_lane_mem32`

## Requirements
- R1: While `rst_n` is low, `rd_data` is all zeros.
- R2: `rd_data` after a rising edge holds the 32-bit word stored at the `addr` sampled at that edge, so read data is valid exactly one cycle after the address.
- R3: Byte enable bit 0 selects low-half nibble-mask bits 1:0 and byte enable bit 1 selects low-half bits 3:2; the low half stores `wdata[15:0]`.
- R4: Byte enable bit 2 selects high-half nibble-mask bits 1:0 and byte enable bit 3 selects high-half bits 3:2; the high half stores `wdata[31:16]`.
- R5: With `be` equal to 4'b0000 nothing is written, and a half whose two byte enables are both clear performs no write.
- R6: Bytes whose enable bit is clear keep their previous contents during a write.
- R7: A read in a writing cycle returns the word as it was before that write (read-first).
- R8: An enabled byte lane n takes `wdata[8n+7:8n]`, and the new value is visible on the next read of that address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all accesses are sampled on the rising edge |
| rst_n | input | 1 | Active-low reset of the read-data register |
| addr | input | ADDR_W | Word address shared by both halves |
| wdata | input | 32 | Write data, lane n in bits [8n+7:8n] |
| be | input | 4 | Byte enables, bit n enables lane n; zero means read only |
| rd_data | output | 32 | Registered read data, one cycle after the address |

## Verification
The bench first fills every word so the contents are known. It then goes after single-lane writes in each of the four lanes. A design that routed a byte enable to the wrong half or the wrong nibble pair would corrupt a neighbouring byte, or would miss its own. Writes with all enables clear but busy write data are also tested, because a block that derived the write strobe from data or address activity would overwrite the word. Back-to-back write-then-read of the same address exposes a design that returns the new data in the writing cycle, or that delivers read data a cycle early or late.

// File: rtl/blm_pkg.sv
package blm_pkg;
  localparam int WORD_W  = 32;
  localparam int HALF_W  = 16;
  localparam int NIB_W   = 4;
  localparam int HALVES  = WORD_W / HALF_W;
  localparam int NIBS    = HALF_W / NIB_W;
  localparam int BYTES   = WORD_W / 8;
  localparam int BE_HALF = BYTES / HALVES;

  typedef logic [NIBS-1:0]   nib_mask_t;
  typedef logic [HALF_W-1:0] half_word_t;

  // Expand the two byte enables of one half into its nibble mask:
  // each byte covers two adjacent nibble-mask bits.
  function automatic nib_mask_t be_to_nib_mask(input logic [BE_HALF-1:0] be_half);
    nib_mask_t m;
    for (int n = 0; n < NIBS; n++) begin
      m[n] = be_half[n / 2];
    end
    return m;
  endfunction

  // Merge new data into an old half-word under a nibble mask.
  function automatic half_word_t nib_merge(input half_word_t old_v,
                                           input half_word_t new_v,
                                           input nib_mask_t  mask);
    half_word_t r;
    for (int n = 0; n < NIBS; n++) begin
      r[n*NIB_W +: NIB_W] = mask[n] ? new_v[n*NIB_W +: NIB_W]
                                    : old_v[n*NIB_W +: NIB_W];
    end
    return r;
  endfunction
endpackage

// File: rtl/blm_lane_map.sv
module blm_lane_map
  import blm_pkg::*;
(
  input  logic [BYTES-1:0]             be,
  output logic [HALVES-1:0][NIBS-1:0]  mask,
  output logic [HALVES-1:0]            wr
);
  for (genvar h = 0; h < HALVES; h++) begin : g_half
    assign mask[h] = be_to_nib_mask(be[h*BE_HALF +: BE_HALF]);
    assign wr[h]   = |mask[h];
  end
endmodule

// File: rtl/blm_half_ram.sv
module blm_half_ram
  import blm_pkg::*;
#(
  parameter int ADDR_W = 10,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  nib_mask_t         mask,
  input  half_word_t        wdata,
  output half_word_t        rdata
);
  half_word_t store [DEPTH];

  // Storage has no reset: contents are undefined until written.
  always_ff @(posedge clk) begin
    if (wr) begin
      store[addr] <= nib_merge(store[addr], wdata, mask);
    end
  end

  // Read-first registered output.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else begin
      rdata <= store[addr];
    end
  end
endmodule

// File: rtl/byte_lane_mem32.sv
module byte_lane_mem32
  import blm_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic [3:0]        be,
  output logic [31:0]       rd_data
);
  logic [HALVES-1:0][NIBS-1:0] mask_h;
  logic [HALVES-1:0]           wr_h;

  // Named events for the checker.
  logic [NIBS-1:0] mask_lo, mask_hi;
  logic            wr_lo, wr_hi;

  blm_lane_map u_map (
    .be   (be),
    .mask (mask_h),
    .wr   (wr_h)
  );

  assign mask_lo = mask_h[0];
  assign mask_hi = mask_h[1];
  assign wr_lo   = wr_h[0];
  assign wr_hi   = wr_h[1];

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    blm_half_ram #(.ADDR_W(ADDR_W)) u_ram (
      .clk   (clk),
      .rst_n (rst_n),
      .addr  (addr),
      .wr    (wr_h[h]),
      .mask  (mask_h[h]),
      .wdata (wdata[h*HALF_W +: HALF_W]),
      .rdata (rd_data[h*HALF_W +: HALF_W])
    );
  end
endmodule

// File: rtl/blm_checker.sv
module blm_checker #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wdata,
  input logic [3:0]        be,
  input logic [31:0]       rd_data,
  input logic [3:0]        mask_lo,
  input logic [3:0]        mask_hi,
  input logic              wr_lo,
  input logic              wr_hi
);
  logic [1:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end
  logic warm;
  assign warm = (since_rst == 2'd3);

  // R1: read data is zero during reset
  always @(negedge clk) begin
    if (!rst_n) assert_reset_zero_R1: assert (rd_data == '0);
  end

  // R3: low-half mask set in pairs and only for low byte enables
  assert_lo_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(mask_lo) % 2 == 0) && ((mask_lo != '0) == (be[1:0] != '0)));

  // R4: high-half mask set in pairs and only for high byte enables
  assert_hi_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(mask_hi) % 2 == 0) && ((mask_hi != '0) == (be[3:2] != '0)));

  // R5: no byte enables means no write strobe in either half
  assert_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (be == 4'b0000) |-> (!wr_lo && !wr_hi));

  // R2: repeated read of the same address with no writes is stable
  assert_read_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && $past(be) == 4'b0 && $past(be, 2) == 4'b0 &&
     $past(addr) == $past(addr, 2)) |-> $stable(rd_data));

  // R8: full-word write followed by a read of that address returns the data
  assert_write_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && $past(be, 2) == 4'hF && $past(be) == 4'h0 &&
     $past(addr) == $past(addr, 2)) |-> (rd_data == $past(wdata, 2)));
endmodule

bind byte_lane_mem32 blm_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .addr    (addr),
  .wdata   (wdata),
  .be      (be),
  .rd_data (rd_data),
  .mask_lo (mask_lo),
  .mask_hi (mask_hi),
  .wr_lo   (wr_lo),
  .wr_hi   (wr_hi)
);

// File: tb/tb_byte_lane_mem32.sv
`timescale 1ns/1ps
module tb_byte_lane_mem32;
  localparam int ADDR_W = 10;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0]       wdata = '0;
  logic [3:0]        be = '0;
  logic [31:0]       rd_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [31:0] ref_mem [DEPTH];

  always #5 clk = ~clk;

  byte_lane_mem32 #(.ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .be(be), .rd_data(rd_data)
  );

  // Bench model of a byte-enabled write: lane by lane.
  function automatic logic [31:0] apply_be(input logic [31:0] old_w,
                                           input logic [31:0] new_w,
                                           input logic [3:0] en);
    logic [31:0] r = old_w;
    for (int b = 0; b < 4; b++) if (en[b]) r[b*8 +: 8] = new_w[b*8 +: 8];
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  // One access: drive at negedge, check read data at the next negedge.
  task automatic access(input logic [ADDR_W-1:0] a, input logic [3:0] e,
                        input logic [31:0] d, input string req, input bit do_chk);
    logic [31:0] exp_rd;
    addr = a; be = e; wdata = d;
    exp_rd = ref_mem[a];                 // read-first value
    @(negedge clk);
    if (do_chk) check(req, rd_data, exp_rd);
    ref_mem[a] = apply_be(ref_mem[a], d, e);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", rd_data, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // Fill every word so all contents are known.
    for (int i = 0; i < DEPTH; i++) access(i[ADDR_W-1:0], 4'hF, 32'hA5000000 ^ (i * 32'h00010203), "R8", 1'b0);
    // Read back a spread of words.
    for (int i = 0; i < DEPTH; i += 37) access(i[ADDR_W-1:0], 4'h0, 32'hFFFFFFFF, "R2", 1'b1);

    // Directed: each lane alone, then read back.
    for (int b = 0; b < 4; b++) begin
      access(10'd5, 4'b0001 << b, 32'h11223344 ^ {4{8'(b)}} ^ 32'hF0F0F0F0, "R6", 1'b1);
      access(10'd5, 4'b0000, 32'h0, (b < 2) ? "R3" : "R4", 1'b1);
    end
    // Zero enables with busy data must not write.
    access(10'd9, 4'b0000, 32'hDEADBEEF, "R5", 1'b1);
    access(10'd9, 4'b0000, 32'h0BADF00D, "R5", 1'b1);
    access(10'd9, 4'b0000, 32'h0, "R5", 1'b1);
    // Read-first: two writes back to back to the same word.
    access(10'd12, 4'hF, 32'hCAFEF00D, "R7", 1'b1);
    access(10'd12, 4'hF, 32'h12345678, "R7", 1'b1);
    access(10'd12, 4'h0, 32'h0, "R8", 1'b1);
    // Half-word writes on each half.
    access(10'd20, 4'b0011, 32'h99887766, "R3", 1'b1);
    access(10'd20, 4'b1100, 32'h55443322, "R4", 1'b1);
    access(10'd20, 4'b0000, 32'h0, "R6", 1'b1);

    // Constrained random mix over a small address window.
    void'($urandom(32'd1234));
    for (int k = 0; k < 3000; k++) begin
      logic [ADDR_W-1:0] a = ADDR_W'($urandom_range(0, 15));
      logic [3:0] e = ($urandom_range(0, 3) == 0) ? 4'h0 : 4'($urandom);
      access(a, e, $urandom, "R6", 1'b1);
    end
    // Final sweep of the window.
    for (int i = 0; i < 16; i++) access(i[ADDR_W-1:0], 4'h0, 32'h0, "R8", 1'b1);

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule